// File: doc/BRIEF.md
# Instruction Cache with Hit-Under-Fill

This block is a read-only, four-way set-associative instruction cache with 128 sets. Each line holds 32 bytes, kept as four 8-byte beats, along with one address tag and one valid bit. The fetch unit presents a double-word address on `fetch_req`/`fetch_addr` and holds it until `fetch_ack`. A hit is acknowledged in the same cycle, with the data taken from the arrays.

On a miss, the block allocates a victim way and drops that way's valid bit. It then issues a one-cycle `mem_req` carrying the address of the requested double word. Memory returns the line one beat per `mem_beat_valid`, starting at the critical beat and wrapping: a requested beat 2 arrives in the order 2, 3, 0, 1. Each beat goes directly into the data array. The critical beat is passed to the fetch unit in the same cycle it arrives.

After that first beat, the cache does not stall:
- Fetches that hit other lines are served while the refill runs.
- Fetches to beats of the line being loaded that have already arrived are served at once.
- A fetch to a beat that has not yet arrived waits and is served in the cycle that beat shows up.

A second miss waits until the refill ends. The line's valid bit is set when its last beat is written. A one-cycle `inv_req` clears every valid bit in one clock. If it comes during a refill, it is held until the refill ends and `inv_busy` reports the held request. No line is ever written except by a refill.

Top module: `icache_hitfill`

## Requirements
- R1: A fetch to a valid resident line is acknowledged in the same cycle it is presented, with the stored double word.
- R2: A miss while no refill runs raises `mem_req` for exactly one cycle, the cycle after the fetch is presented. `mem_addr` holds the fetch address with bits [2:0] zero.
- R3: The critical double word is acknowledged to the fetch unit in the same cycle it is presented on `mem_beat_data`.
- R4: The k-th beat of a refill (k = 0..3) is stored as beat (critical + k) mod 4 of the line; the beat index is address bits [4:3].
- R5: During a refill, after the critical beat, fetches that hit other resident lines are acknowledged in the same cycle.
- R6: During a refill, a fetch to a beat of the loading line that has arrived is acknowledged at once. A fetch to a beat not yet arrived is held without acknowledge until the cycle that beat arrives, and is then forwarded.
- R7: A miss to another line during a refill issues no `mem_req` and gets no acknowledge until the refill has ended.
- R8: After the last beat of a refill, every beat of that line hits without a new memory request.
- R9: `inv_req` while no refill runs invalidates all lines at that clock edge; `inv_busy` stays low.
- R10: `inv_req` during a refill sets `inv_busy` from the next cycle. Resident lines still hit until the refill ends. All lines, including the one just loaded, are then invalidated and `inv_busy` falls.
- R11: After reset, all lines are invalid and `fetch_ack`, `mem_req` and `inv_busy` are low.
- R12: A victim is the lowest invalid way of the set, so four distinct lines mapping to one set all stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 32 | Fetch byte address (double-word granular) |
| fetch_ack | output | 1 | Fetch served this cycle |
| fetch_data | output | 64 | Fetched double word, valid with `fetch_ack` |
| inv_req | input | 1 | One-cycle invalidate-all command |
| inv_busy | output | 1 | Invalidate held behind a running refill |
| mem_req | output | 1 | One-cycle refill request |
| mem_addr | output | 32 | Critical double-word address of the refill |
| mem_beat_valid | input | 1 | A refill beat is present |
| mem_beat_data | input | 64 | Refill beat data |

## Verification
Hit and forwarding results are combinational: the bench drives a fetch after the falling edge and samples `fetch_ack` one time unit later in the same cycle. A zero-cycle wait therefore means a same-cycle hit, and a stalled fetch is counted in whole cycles until its acknowledge. `mem_req` and `inv_busy` are registered. They are read in the cycle after the stimulus edge, and the memory model takes a request at the falling edge of the cycle where `mem_req` is high. Invalidate effects are judged by whether the next fetch makes a memory request. They are checked only once the model has delivered the last beat and two further cycles have passed, covering the return to idle and the held clear.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int ADDR_W = 32;
    localparam int BEAT_W = 64;
    localparam int BEATS  = 4;
    localparam int SETS   = 128;
    localparam int WAYS   = 4;

    localparam int OFF_W  = $clog2(BEAT_W / 8);
    localparam int BIDX_W = $clog2(BEATS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - BIDX_W - OFF_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [BIDX_W-1:0] bidx_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        tag_t  tag;
        set_t  set;
        bidx_t beat;
    } fetch_loc_t;

    typedef enum logic {FILL_IDLE, FILL_BUSY} fill_state_e;

    // beat position of the k-th beat of a wrapping refill
    function automatic bidx_t wrap_beat(input bidx_t crit, input bidx_t k);
        return crit + k;
    endfunction

    function automatic logic [ADDR_W-1:0] beat_addr(input fetch_loc_t loc);
        return {loc.tag, loc.set, loc.beat, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
    import icache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  set_t  lk_set,
    input  tag_t  lk_tag,
    output logic  hit,
    output way_t  hit_way,
    output way_t  victim_way,
    input  logic  alloc_en,
    input  set_t  alloc_set,
    input  way_t  alloc_way,
    input  tag_t  alloc_tag,
    input  logic  commit_en,
    input  set_t  commit_set,
    input  way_t  commit_way,
    input  logic  clear_all
);
    logic [WAYS-1:0] valid_q [SETS];
    tag_t            tag_q   [SETS][WAYS];
    way_t            rr_q;
    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    always_comb begin
        hit        = |match;
        hit_way    = '0;
        victim_way = rr_q;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[lk_set][w]) victim_way = way_t'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = way_t'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            rr_q <= '0;
        end else begin
            if (clear_all) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end
            if (alloc_en) begin
                valid_q[alloc_set][alloc_way] <= 1'b0;
                tag_q[alloc_set][alloc_way]   <= alloc_tag;
                rr_q                          <= rr_q + 1'b1;
            end
            if (commit_en) valid_q[commit_set][commit_way] <= 1'b1;
        end
    end

    // R12
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store
    import icache_pkg::*;
(
    input  logic  clk,
    input  set_t  rd_set,
    input  way_t  rd_way,
    input  bidx_t rd_beat,
    output beat_t rd_data,
    input  logic  wr_en,
    input  set_t  wr_set,
    input  way_t  wr_way,
    input  bidx_t wr_beat,
    input  beat_t wr_data
);
    beat_t line_q [SETS][WAYS][BEATS];

    assign rd_data = line_q[rd_set][rd_way][rd_beat];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_set][wr_way][wr_beat] <= wr_data;
    end
endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  fetch_loc_t        start_loc,
    input  way_t              start_way,
    input  logic              beat_valid,
    input  logic              inv_req,
    output logic              busy,
    output tag_t              fill_tag,
    output set_t              fill_set,
    output way_t              fill_way,
    output logic [BEATS-1:0]  got,
    output bidx_t             cur_beat,
    output logic              beat_wr,
    output logic              commit,
    output logic              clear_all,
    output logic              inv_busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr
);
    fill_state_e      state_q;
    tag_t             tag_q;
    set_t             set_q;
    way_t             way_q;
    bidx_t            crit_q;
    bidx_t            cnt_q;
    logic [BEATS-1:0] got_q;
    logic             mem_req_q;
    logic             inv_pend_q;
    fetch_loc_t       req_loc;

    assign busy      = (state_q == FILL_BUSY);
    assign cur_beat  = wrap_beat(crit_q, cnt_q);
    assign beat_wr   = busy && beat_valid;
    assign commit    = beat_wr && (cnt_q == BIDX_W'(BEATS - 1));
    assign clear_all = !busy && (inv_req || inv_pend_q);
    assign fill_tag  = tag_q;
    assign fill_set  = set_q;
    assign fill_way  = way_q;
    assign got       = got_q;
    assign inv_busy  = inv_pend_q;
    assign mem_req   = mem_req_q;
    assign req_loc   = '{tag: tag_q, set: set_q, beat: crit_q};
    assign mem_addr  = beat_addr(req_loc);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FILL_IDLE;
            tag_q      <= '0;
            set_q      <= '0;
            way_q      <= '0;
            crit_q     <= '0;
            cnt_q      <= '0;
            got_q      <= '0;
            mem_req_q  <= 1'b0;
            inv_pend_q <= 1'b0;
        end else begin
            mem_req_q <= 1'b0;
            if (start && !busy) begin
                state_q   <= FILL_BUSY;
                tag_q     <= start_loc.tag;
                set_q     <= start_loc.set;
                crit_q    <= start_loc.beat;
                way_q     <= start_way;
                cnt_q     <= '0;
                got_q     <= '0;
                mem_req_q <= 1'b1;
            end else if (beat_wr) begin
                got_q[cur_beat] <= 1'b1;
                cnt_q           <= cnt_q + 1'b1;
                if (commit) begin
                    state_q <= FILL_IDLE;
                    got_q   <= '0;
                end
            end
            if (busy && inv_req)  inv_pend_q <= 1'b1;
            else if (clear_all)   inv_pend_q <= 1'b0;
        end
    end

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_q |=> !mem_req_q);
    // R7
    req_only_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_q) |-> $rose(busy));
    // R4
    beat_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_wr && !commit) |=> ($countones(got_q) == $countones($past(got_q)) + 1));
    // R8
    commit_ends_fill_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);
    // R10
    inv_held_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_pend_q && busy) |=> inv_pend_q);
    // R10
    inv_release_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_pend_q && !busy) |=> !inv_pend_q);
endmodule

// File: rtl/icache_hitfill.sv
module icache_hitfill
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ack,
    output logic [BEAT_W-1:0] fetch_data,
    input  logic              inv_req,
    output logic              inv_busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_valid,
    input  logic [BEAT_W-1:0] mem_beat_data
);
    fetch_loc_t       loc;
    logic             unused_low;
    logic             hit;
    way_t             hit_way, victim_way, rd_way;
    logic             busy, beat_wr, commit, clear_all;
    tag_t             fill_tag;
    set_t             fill_set;
    way_t             fill_way;
    logic [BEATS-1:0] got;
    bidx_t            cur_beat;
    beat_t            rd_data;
    logic             line_match, beat_now, miss_start;

    assign loc        = '{tag: fetch_addr[ADDR_W-1 -: TAG_W],
                          set: fetch_addr[OFF_W+BIDX_W +: SET_W],
                          beat: fetch_addr[OFF_W +: BIDX_W]};
    assign unused_low = ^fetch_addr[OFF_W-1:0];

    assign line_match = busy && (loc.tag == fill_tag) && (loc.set == fill_set);
    assign beat_now   = beat_wr && (cur_beat == loc.beat);
    assign miss_start = fetch_req && !busy && !hit;
    assign rd_way     = line_match ? fill_way : hit_way;

    always_comb begin
        if (line_match) fetch_ack = fetch_req && (got[loc.beat] || beat_now);
        else            fetch_ack = fetch_req && hit;
        fetch_data = (line_match && beat_now) ? mem_beat_data : rd_data;
    end

    icache_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .lk_set     (loc.set),
        .lk_tag     (loc.tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .alloc_en   (miss_start),
        .alloc_set  (loc.set),
        .alloc_way  (victim_way),
        .alloc_tag  (loc.tag),
        .commit_en  (commit),
        .commit_set (fill_set),
        .commit_way (fill_way),
        .clear_all  (clear_all)
    );

    icache_data_store u_data (
        .clk     (clk),
        .rd_set  (loc.set),
        .rd_way  (rd_way),
        .rd_beat (loc.beat),
        .rd_data (rd_data),
        .wr_en   (beat_wr),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_beat (cur_beat),
        .wr_data (mem_beat_data)
    );

    icache_refill_ctrl u_refill (
        .clk        (clk),
        .rst        (rst),
        .start      (miss_start),
        .start_loc  (loc),
        .start_way  (victim_way),
        .beat_valid (mem_beat_valid),
        .inv_req    (inv_req),
        .busy       (busy),
        .fill_tag   (fill_tag),
        .fill_set   (fill_set),
        .fill_way   (fill_way),
        .got        (got),
        .cur_beat   (cur_beat),
        .beat_wr    (beat_wr),
        .commit     (commit),
        .clear_all  (clear_all),
        .inv_busy   (inv_busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr)
    );

    // R3
    crit_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && line_match && beat_now) |-> (fetch_ack && fetch_data == mem_beat_data));
    // R6
    pending_beat_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && line_match && !got[loc.beat] && !mem_beat_valid) |-> !fetch_ack);
endmodule

// File: tb/test_icache_hitfill.sv
module test_icache_hitfill;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack;
    logic [63:0] fetch_data;
    logic        inv_req;
    logic        inv_busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_beat_valid;
    logic [63:0] mem_beat_data;

    always #5 clk = ~clk;

    icache_hitfill i_icache_hitfill (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .inv_req(inv_req),
        .inv_busy(inv_busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int pend = 0;
    int req_cnt = 0;
    int mem_allow = 1 << 30;
    bit mem_gaps = 0;
    logic [26:0] mbase;
    logic [1:0]  mcur;
    logic [28:0] last_req;
    int lat;
    bit fwd, miss;
    bit filled [4][4];

    function automatic logic [63:0] model(input logic [31:0] a);
        logic [31:0] b;
        b = {a[31:3], 3'b000};
        return {b ^ 32'hC3A5_5A3C, ~b};
    endfunction

    function automatic logic [31:0] mk(input int t, input int s, input int b);
        return {t[19:0], s[6:0], b[1:0], 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // memory model: beats in wrap order from the critical beat
    initial begin
        mem_beat_valid = 1'b0;
        mem_beat_data  = '0;
        forever begin
            @(negedge clk);
            mem_beat_valid = 1'b0;
            if (pend > 0 && mem_allow > 0 && (!mem_gaps || $urandom_range(0, 2) != 0)) begin
                mem_beat_valid = 1'b1;
                mem_beat_data  = model({mbase, mcur, 3'b000});
                mcur++;
                pend--;
                mem_allow--;
            end
            if (mem_req) begin
                check(pend == 0, "R7 request during refill", 64'(pend), 64'd0);
                check(mem_addr[2:0] == 3'b000, "R2 mem_addr low bits", 64'(mem_addr[2:0]), 64'd0);
                pend     = 4;
                mbase    = mem_addr[31:5];
                mcur     = mem_addr[4:3];
                last_req = mem_addr[31:3];
                req_cnt++;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, output int l, output bit f, output bit m);
        int rc0;
        rc0 = req_cnt;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        l = 0;
        f = 0;
        forever begin
            #1;
            if (fetch_ack) begin
                f = mem_beat_valid;
                check(fetch_data == model(a), "R4 fetched data", fetch_data, model(a));
                break;
            end
            l++;
            if (l > 2000) begin
                check(0, "R1 fetch never acknowledged", 64'(l), 64'd0);
                break;
            end
            @(negedge clk);
        end
        m = (req_cnt != rc0);
        @(posedge clk);
        #1 fetch_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (pend != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        inv_req = 1'b1;
        @(negedge clk);
        inv_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        int unsigned sd;
        logic [31:0] a;
        int rc;
        sd = $urandom(32'd20240611);
        rst = 1'b1;
        fetch_req = 1'b0;
        fetch_addr = '0;
        inv_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        check(fetch_ack == 1'b0, "R11 ack after reset", 64'(fetch_ack), 64'd0);
        check(mem_req == 1'b0, "R11 mem_req after reset", 64'(mem_req), 64'd0);
        check(inv_busy == 1'b0, "R11 inv_busy after reset", 64'(inv_busy), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: first miss, critical beat 2
        a = mk(1, 5, 2);
        fetch(a, lat, fwd, miss);
        check(miss, "R2 miss requests refill", 64'(miss), 64'd1);
        check(last_req == a[31:3], "R2 mem_addr", 64'(last_req), 64'(a[31:3]));
        check(fwd, "R3 critical forwarded on arrival", 64'(fwd), 64'd1);
        wait_idle();

        // R8 / R4: all beats of the loaded line hit
        for (int b = 0; b < 4; b++) begin
            fetch(mk(1, 5, b), lat, fwd, miss);
            check(lat == 0 && !miss, "R8 loaded line hits", 64'(lat), 64'd0);
        end

        // R12: four lines in one set stay resident
        fetch(mk(2, 9, 0), lat, fwd, miss); wait_idle();
        for (int t = 3; t <= 5; t++) begin
            fetch(mk(t, 5, 1), lat, fwd, miss); wait_idle();
        end
        for (int t = 1; t <= 5; t++) begin
            if (t == 2) continue;
            fetch(mk(t, 5, 3), lat, fwd, miss);
            check(lat == 0 && !miss, "R12 set holds four lines", 64'(lat), 64'd0);
        end

        // R5 / R6: hit under fill and forwarding of later beats
        mem_allow = 1;
        fetch(mk(7, 20, 2), lat, fwd, miss);
        check(miss && fwd, "R3 critical of held refill", 64'(fwd), 64'd1);
        fetch(mk(2, 9, 0), lat, fwd, miss);
        check(lat == 0 && !miss, "R5 other line hits during refill", 64'(lat), 64'd0);
        fetch(mk(7, 20, 2), lat, fwd, miss);
        check(lat == 0 && !miss, "R6 arrived beat served", 64'(lat), 64'd0);
        fork
            fetch(mk(7, 20, 0), lat, fwd, miss);
            begin
                repeat (3) @(negedge clk);
                mem_allow = 2;
            end
        join
        check(lat >= 3 && fwd, "R6 pending beat stalls then forwards", 64'(lat), 64'd3);
        fetch(mk(7, 20, 3), lat, fwd, miss);
        check(lat == 0 && !miss, "R6 earlier arrived beat", 64'(lat), 64'd0);

        // R7: second miss waits for the refill to end
        rc = req_cnt;
        fork
            fetch(mk(8, 21, 1), lat, fwd, miss);
            begin
                repeat (6) @(negedge clk);
                #1;
                check(req_cnt == rc, "R7 no request while refilling", 64'(req_cnt), 64'(rc));
                check(fetch_ack == 1'b0, "R7 second miss not acked", 64'(fetch_ack), 64'd0);
                mem_allow = 1 << 30;
            end
        join
        check(miss, "R7 second miss served after refill", 64'(miss), 64'd1);
        wait_idle();
        fetch(mk(7, 20, 1), lat, fwd, miss);
        check(lat == 0 && !miss, "R8 line complete after last beat", 64'(lat), 64'd0);

        // R9: invalidate while idle
        pulse_inv();
        #1 check(inv_busy == 1'b0, "R9 inv_busy idle", 64'(inv_busy), 64'd0);
        fetch(mk(2, 9, 0), lat, fwd, miss);
        check(miss, "R9 line gone after invalidate", 64'(miss), 64'd1);
        wait_idle();

        // R10: invalidate during refill is held
        mem_allow = 1;
        fetch(mk(9, 30, 0), lat, fwd, miss);
        pulse_inv();
        #1 check(inv_busy == 1'b1, "R10 inv_busy during refill", 64'(inv_busy), 64'd1);
        fetch(mk(2, 9, 0), lat, fwd, miss);
        check(lat == 0 && !miss, "R10 lines kept until refill ends", 64'(lat), 64'd0);
        mem_allow = 1 << 30;
        wait_idle();
        check(inv_busy == 1'b0, "R10 inv_busy released", 64'(inv_busy), 64'd0);
        fetch(mk(2, 9, 0), lat, fwd, miss);
        check(miss, "R10 old line cleared", 64'(miss), 64'd1);
        wait_idle();
        fetch(mk(9, 30, 2), lat, fwd, miss);
        check(miss, "R10 refilled line cleared", 64'(miss), 64'd1);
        wait_idle();

        // random phase against a residency shadow
        pulse_inv();
        wait_idle();
        mem_gaps = 1;
        for (int s = 0; s < 4; s++) for (int t = 0; t < 4; t++) filled[s][t] = 0;
        for (int i = 0; i < 300; i++) begin
            int si, ti, bi;
            int sets [4];
            sets = '{3, 40, 77, 126};
            if ($urandom_range(0, 24) == 0) begin
                pulse_inv();
                for (int s = 0; s < 4; s++) for (int t = 0; t < 4; t++) filled[s][t] = 0;
            end
            si = $urandom_range(0, 3);
            ti = $urandom_range(0, 3);
            bi = $urandom_range(0, 3);
            fetch(mk(11 + ti, sets[si], bi), lat, fwd, miss);
            if (filled[si][ti]) begin
                check(lat == 0 && !miss, "R1 random hit", 64'(lat), 64'd0);
            end else begin
                check(miss && fwd, "R2 random miss", 64'(miss), 64'd1);
            end
            filled[si][ti] = 1;
            wait_idle();
        end
        finish_run();
    end
endmodule